// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a memory-mapped watchdog. A 16-bit up-counter advances once per prescaled timer tick. Software sets the timeout by loading a start value, so the time left is the distance to the 16-bit wrap: 65536 minus the current count, in prescaled ticks. When the counter wraps past 0xFFFF, the block latches a sticky overflow flag and raises a reset request for a fixed number of clock cycles. Every register write must carry a key in its upper data bits. A write without the right key is dropped without any effect.

Software sees three 32-bit registers. Offset 0 holds the counter. Offset 4 holds control A: enable in bit 7, write-busy in bit 5 (read-only), overflow in bit 4 and prescaler code in bits 2:0. Offset 8 holds control B, a plain 8-bit register. After any accepted write, the write-busy flag stays set for a fixed number of timer ticks, and the block drops every write that arrives in that window. Software therefore polls the flag before it sets the enable bit. There are two resets. `por_n` clears everything. `wrst_n` is the warm reset that the block's own request is meant to trigger. It clears everything except the overflow flag, so that after the reboot software can tell that the watchdog caused it.

The block contains two state machines. The write gate has two states:
- WR_OPEN goes to WR_BUSY on an accepted write (transition *accept*).
- WR_BUSY goes back to WR_OPEN once the busy ticks have elapsed (transition *drain*).

The reset-request machine also has two states:
- AL_QUIET goes to AL_FIRE on a counter wrap (transition *trip*).
- AL_FIRE goes back to AL_QUIET after the pulse length (transition *release*).
- A wrap while in AL_FIRE reloads the pulse length (transition *retrip*).

Top module: `wdog_keyed`

## Requirements
- R1: After `por_n` is low at a clock edge, all three registers read 0 and `rst_req` is 0.
- R2: A write to offset 0 with data bits 31:16 equal to 0x5A5A loads bits 15:0 into the counter, which then reads back zero-extended at offset 0.
- R3: A write to offset 4 or 8 takes effect only when data bits 31:8 equal 0xA5A5A5. Bits 7:0 carry the value. Control B reads back its 8 bits at offset 8.
- R4: A write whose key does not match changes no register and does not start a busy window.
- R5: After an accepted write, control A bit 5 reads 1 for the next 2 timer ticks. Every write that arrives while bit 5 is 1 is dropped, whatever its key.
- R6: While control A bit 7 (enable) is 0, the counter holds its value.
- R7: While enabled, the counter increments once per 2^k ticks. Code 0..7 in control A bits 2:0 selects a divide ratio of 1, 4, 16, 32, 64, 128, 1024 or 4096. The prescaler phase restarts at every accepted control A write.
- R8: A wrap from 0xFFFF to 0 sets control A bit 4. From the clock edge that wraps the counter, `rst_req` is high for exactly 16 clock cycles.
- R9: With 0xFFFF loaded and code 0, the first tick after the enabling write overflows the counter.
- R10: `wrst_n` clears the counter, the enable bit, the prescaler code, control B and the busy window, but keeps control A bit 4. Only `por_n` clears that bit.
- R11: Control A bit 4 clears only on an accepted control A write with bit 4 equal to 0. Writing 1 to bit 4 leaves the flag as it is.
- R12: Reads from any address other than 0, 4 and 8 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| wrst_n | input | 1 | Warm reset, active low, synchronous, keeps the overflow flag |
| tick | input | 1 | Timer clock enable, one cycle per timer tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data, key in the upper bits |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | Reset request pulse after an overflow |

## Verification
A behavioural model runs next to the design and is compared with read data and `rst_req` on every clock. The stimulus combines several input patterns:
- Dense ticks and sparse ticks. Sparse ticks show that the busy window is measured in timer ticks, not in clock cycles.
- Wrong keys on the counter and control registers. These separate key checking from address decoding.
- Writes issued inside the busy window. These show that even correctly keyed writes are dropped while the flag is set.
- Runs with prescaler codes 0, 2 and 7. These check that the divide ratio and the phase restart land on the exact cycle.
- A warm reset and then a power-on reset after an overflow. These separate the two reset domains of the overflow flag.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam logic [15:0] CNT_KEY  = 16'h5A5A;
    localparam logic [23:0] CTL_KEY  = 24'hA5A5A5;
    localparam int unsigned OFS_CNT  = 0;
    localparam int unsigned OFS_CTLA = 4;
    localparam int unsigned OFS_CTLB = 8;
    localparam int unsigned BIT_EN   = 7;
    localparam int unsigned BIT_BUSY = 5;
    localparam int unsigned BIT_OVF  = 4;

    typedef enum logic [1:0] {SEL_CNT, SEL_CTLA, SEL_CTLB, SEL_NONE} reg_sel_e;
    typedef enum logic {WR_OPEN, WR_BUSY} wr_state_e;
    typedef enum logic {AL_QUIET, AL_FIRE} al_state_e;

    // log2 of the prescaler divide ratio for each code
    function automatic logic [3:0] ratio_shift(input logic [2:0] code);
        logic [3:0] s;
        unique case (code)
            3'd0:    s = 4'd0;
            3'd1:    s = 4'd2;
            3'd2:    s = 4'd4;
            3'd3:    s = 4'd5;
            3'd4:    s = 4'd6;
            3'd5:    s = 4'd7;
            3'd6:    s = 4'd10;
            default: s = 4'd12;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/wdog_regif.sv
`timescale 1ns/1ps
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int unsigned AW         = 4,
    parameter int unsigned CW         = 16,
    parameter int unsigned BUSY_TICKS = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wrst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic          wrap_evt,
    output reg_sel_e      sel_o,
    output logic          busy_o,
    output logic          en_o,
    output logic [2:0]    cks_o,
    output logic          ovf_o,
    output logic [7:0]    ctlb_o,
    output logic          cnt_load_o,
    output logic [CW-1:0] cnt_val_o,
    output logic          ctla_wr_o
);
    localparam int unsigned BW = $clog2(BUSY_TICKS + 1);

    logic          rst_n;
    logic          key_ok;
    logic          accept;
    wr_state_e     st_q, st_d;
    logic [BW-1:0] left_q, left_d;
    logic          en_q, ovf_q;
    logic [2:0]    cks_q;
    logic [7:0]    ctlb_q;

    assign rst_n = por_n & wrst_n;

    always_comb begin
        if (addr == AW'(OFS_CNT))       sel_o = SEL_CNT;
        else if (addr == AW'(OFS_CTLA)) sel_o = SEL_CTLA;
        else if (addr == AW'(OFS_CTLB)) sel_o = SEL_CTLB;
        else                            sel_o = SEL_NONE;
    end

    always_comb begin
        unique case (sel_o)
            SEL_CNT:            key_ok = (wdata[31:16] == CNT_KEY);
            SEL_CTLA, SEL_CTLB: key_ok = (wdata[31:8] == CTL_KEY);
            default:            key_ok = 1'b0;
        endcase
    end

    assign accept = wr_en && (st_q == WR_OPEN) && key_ok;

    // write gate: next state
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        unique case (st_q)
            WR_OPEN: begin
                if (accept) begin
                    st_d   = WR_BUSY;
                    left_d = BW'(BUSY_TICKS - 1);
                end
            end
            WR_BUSY: begin
                if (tick) begin
                    if (left_q == '0) st_d = WR_OPEN;
                    else              left_d = left_q - 1'b1;
                end
            end
        endcase
    end

    // write gate: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WR_OPEN;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    // write gate: outputs
    always_comb begin
        busy_o     = (st_q == WR_BUSY);
        cnt_load_o = accept && (sel_o == SEL_CNT);
        ctla_wr_o  = accept && (sel_o == SEL_CTLA);
        cnt_val_o  = wdata[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cks_q  <= '0;
            ctlb_q <= '0;
        end else if (accept) begin
            if (sel_o == SEL_CTLA) begin
                en_q  <= wdata[BIT_EN];
                cks_q <= wdata[2:0];
            end
            if (sel_o == SEL_CTLB) ctlb_q <= wdata[7:0];
        end
    end

    // overflow flag: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ovf_q <= 1'b0;
        end else if (wrst_n) begin
            if (wrap_evt)
                ovf_q <= 1'b1;
            else if (accept && (sel_o == SEL_CTLA) && !wdata[BIT_OVF])
                ovf_q <= 1'b0;
        end
    end

    assign en_o   = en_q;
    assign cks_o  = cks_q;
    assign ovf_o  = ovf_q;
    assign ctlb_o = ctlb_q;

    assert_busy_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
    assert_locked_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy_o) |=> $stable({en_q, cks_q, ctlb_q}));
    assert_wrong_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_o == SEL_CTLA && wdata[31:8] != CTL_KEY) |=> $stable({en_q, cks_q}));
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> ovf_q);
    assert_ovf_warm_R10: assert property (@(posedge clk) disable iff (!por_n)
        !wrst_n |=> $stable(ovf_q));
endmodule

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int unsigned PW = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       clr,
    input  logic [2:0] cks,
    output logic       hit_o
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] term;

    assign term  = PW'((32'd1 << ratio_shift(cks)) - 32'd1);
    assign hit_o = (pre_q == term);

    always_ff @(posedge clk) begin
        if (!rst_n)          pre_q <= '0;
        else if (!en || clr) pre_q <= '0;
        else if (tick)       pre_q <= hit_o ? '0 : pre_q + 1'b1;
    end

    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= term);
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          hit,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    logic [CW-1:0] cnt_q;
    logic          step;

    assign step   = en && tick && hit;
    assign wrap_o = step && (cnt_q == {CW{1'b1}});
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_alarm.sv
`timescale 1ns/1ps
module wdog_alarm
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic rst_req
);
    localparam int unsigned KW = $clog2(PULSE + 1);

    al_state_e     st_q, st_d;
    logic [KW-1:0] k_q, k_d;

    // next state
    always_comb begin
        st_d = st_q;
        k_d  = k_q;
        unique case (st_q)
            AL_QUIET: begin
                if (evt) begin
                    st_d = AL_FIRE;
                    k_d  = KW'(PULSE - 1);
                end
            end
            AL_FIRE: begin
                if (evt)            k_d = KW'(PULSE - 1);
                else if (k_q == '0) st_d = AL_QUIET;
                else                k_d = k_q - 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= AL_QUIET;
            k_q  <= '0;
        end else begin
            st_q <= st_d;
            k_q  <= k_d;
        end
    end

    // outputs
    always_comb rst_req = (st_q == AL_FIRE);

    assert_req_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> rst_req);
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int unsigned AW         = 4,
    parameter int unsigned CW         = 16,
    parameter int unsigned PW         = 12,
    parameter int unsigned BUSY_TICKS = 2,
    parameter int unsigned PULSE      = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wrst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          rst_req
);
    logic          rst_n;
    reg_sel_e      sel;
    logic          busy, en, ovf, cnt_load, ctla_wr, hit, wrap;
    logic [2:0]    cks;
    logic [7:0]    ctlb;
    logic [CW-1:0] cnt_val, cnt;

    assign rst_n = por_n & wrst_n;

    wdog_regif #(.AW(AW), .CW(CW), .BUSY_TICKS(BUSY_TICKS)) u_regif (
        .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .wrap_evt(wrap),
        .sel_o(sel), .busy_o(busy), .en_o(en), .cks_o(cks), .ovf_o(ovf),
        .ctlb_o(ctlb), .cnt_load_o(cnt_load), .cnt_val_o(cnt_val),
        .ctla_wr_o(ctla_wr)
    );

    wdog_prescale #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .clr(ctla_wr),
        .cks(cks), .hit_o(hit)
    );

    wdog_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .hit(hit),
        .load(cnt_load), .load_val(cnt_val), .cnt_o(cnt), .wrap_o(wrap)
    );

    wdog_alarm #(.PULSE(PULSE)) u_alarm (
        .clk(clk), .rst_n(rst_n), .evt(wrap), .rst_req(rst_req)
    );

    always_comb begin
        unique case (sel)
            SEL_CNT:  rdata = DATA_W'(cnt);
            SEL_CTLA: rdata = {24'd0, en, 1'b0, busy, ovf, 1'b0, cks};
            SEL_CTLB: rdata = {24'd0, ctlb};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wrst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        rst_req;

    int vectors = 0;
    int miscompares = 0;
    int tick_gap = 1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_keyed u0 (
        .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rst_req(rst_req)
    );

    // ---------------- behavioural reference ----------------
    int divs[8] = '{1, 4, 16, 32, 64, 128, 1024, 4096};
    int m_cnt = 0, m_en = 0, m_cks = 0, m_ovf = 0, m_ctlb = 0;
    int m_busy = 0, m_pre = 0, m_alarm = 0;
    int a, acc, keyok, hit, step, evt, n_cnt, n_pre, n_busy;

    always @(posedge clk) begin
        if (!por_n) begin
            m_cnt = 0; m_en = 0; m_cks = 0; m_ovf = 0; m_ctlb = 0;
            m_busy = 0; m_pre = 0; m_alarm = 0;
        end else if (!wrst_n) begin
            m_cnt = 0; m_en = 0; m_cks = 0; m_ctlb = 0;
            m_busy = 0; m_pre = 0; m_alarm = 0;
        end else begin
            a = int'(addr);
            keyok = ((a == 0) && (wdata[31:16] == 16'h5A5A)) ||
                    (((a == 4) || (a == 8)) && (wdata[31:8] == 24'hA5A5A5));
            acc  = (wr_en && m_busy == 0 && keyok) ? 1 : 0;
            hit  = (m_pre == divs[m_cks] - 1) ? 1 : 0;
            step = (m_en != 0 && tick && hit != 0) ? 1 : 0;
            evt  = (step != 0 && m_cnt == 65535) ? 1 : 0;
            n_pre  = (m_en == 0 || (acc != 0 && a == 4)) ? 0 :
                     (tick ? ((hit != 0) ? 0 : m_pre + 1) : m_pre);
            n_cnt  = (acc != 0 && a == 0) ? int'(wdata[15:0]) :
                     (step != 0) ? (m_cnt + 1) % 65536 : m_cnt;
            n_busy = (acc != 0) ? 2 : ((tick && m_busy > 0) ? m_busy - 1 : m_busy);
            if (acc != 0 && a == 4) begin
                m_en = int'(wdata[7]); m_cks = int'(wdata[2:0]);
                if (!wdata[4]) m_ovf = 0;
            end
            if (acc != 0 && a == 8) m_ctlb = int'(wdata[7:0]);
            if (evt != 0) m_ovf = 1;
            m_alarm = (evt != 0) ? 16 : ((m_alarm > 0) ? m_alarm - 1 : 0);
            m_pre = n_pre; m_cnt = n_cnt; m_busy = n_busy;
        end
    end

    function automatic logic [31:0] m_read(input int ad);
        case (ad)
            0: return 32'(m_cnt);
            4: return 32'((m_en << 7) | ((m_busy > 0 ? 1 : 0) << 5) | (m_ovf << 4) | m_cks);
            8: return 32'(m_ctlb);
            default: return 32'd0;
        endcase
    endfunction

    // every-clock comparison
    always @(posedge clk) begin
        #1;
        vectors++;
        if (rdata !== m_read(int'(addr))) begin
            miscompares++;
            $display("FAIL R12 read addr %0d: actual=%h expected=%h", addr, rdata, m_read(int'(addr)));
        end
        vectors++;
        if (rst_req !== (m_alarm > 0)) begin
            miscompares++;
            $display("FAIL R8 rst_req: actual=%b expected=%b", rst_req, (m_alarm > 0));
        end
    end

    // ---------------- tick source ----------------
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            if (tick_gap <= 1) tick = 1'b1;
            else begin
                tc++;
                tick = (tc % tick_gap == 0);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] ad, input logic [31:0] d);
        @(negedge clk);
        addr = ad; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] ad, output logic [31:0] v);
        @(negedge clk);
        addr = ad;
        @(posedge clk);
        #1 v = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do peek(4'd4, v); while (v[5]);
    endtask

    // ---------------- scenario ----------------
    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        por_n = 1'b1; wrst_n = 1'b1;

        peek(4'd0, v); expect_eq("R1 counter after power-on", v, 32'd0);
        peek(4'd4, v); expect_eq("R1 control A after power-on", v, 32'd0);
        peek(4'd8, v); expect_eq("R1 control B after power-on", v, 32'd0);

        tick_gap = 8;
        put(4'd0, 32'h1234_0042);
        peek(4'd4, v); expect_eq("R4 bad counter key starts no busy", v, 32'd0);
        peek(4'd0, v); expect_eq("R4 bad counter key dropped", v, 32'd0);
        put(4'd4, 32'hA5A5_A480);
        peek(4'd4, v); expect_eq("R4 bad control key dropped", v, 32'd0);

        put(4'd0, 32'h5A5A_FFF0);
        peek(4'd4, v); expect_eq("R5 busy flag after write", v, 32'h20);
        put(4'd0, 32'h5A5A_0001);
        wait_idle();
        peek(4'd0, v); expect_eq("R2 R5 load kept, busy write dropped", v, 32'h0000_FFF0);

        put(4'd8, 32'hA5A5_A53C);
        wait_idle();
        peek(4'd8, v); expect_eq("R3 control B readback", v, 32'h3C);
        peek(4'd12, v); expect_eq("R12 unmapped offset 12", v, 32'd0);
        peek(4'd2, v); expect_eq("R12 unmapped offset 2", v, 32'd0);

        tick_gap = 1;
        repeat (20) @(posedge clk);
        peek(4'd0, v); expect_eq("R6 hold while disabled", v, 32'h0000_FFF0);

        put(4'd4, 32'hA5A5_A580);
        repeat (15) @(posedge clk);
        #1 expect_eq("R8 no request before wrap", 32'(rst_req), 32'd0);
        @(posedge clk);
        #1 expect_eq("R8 request at wrap", 32'(rst_req), 32'd1);
        n = 1;
        while (rst_req) begin @(posedge clk); #1 if (rst_req) n++; end
        expect_eq("R8 pulse length", 32'(n), 32'd16);
        peek(4'd4, v); expect_eq("R8 overflow flag set", 32'(v[4]), 32'd1);

        wait_idle();
        put(4'd4, 32'hA5A5_A510);
        wait_idle();
        peek(4'd4, v); expect_eq("R11 writing 1 keeps flag", v, 32'h10);
        put(4'd4, 32'hA5A5_A500);
        wait_idle();
        peek(4'd4, v); expect_eq("R11 writing 0 clears flag", v, 32'h00);

        put(4'd0, 32'h5A5A_FFFF);
        wait_idle();
        put(4'd4, 32'hA5A5_A580);
        expect_eq("R9 no request at enable edge", 32'(rst_req), 32'd0);
        @(posedge clk);
        #1 expect_eq("R9 overflow on first tick", 32'(rst_req), 32'd1);
        repeat (20) @(posedge clk);

        @(negedge clk); wrst_n = 1'b0;
        @(negedge clk); wrst_n = 1'b1;
        peek(4'd4, v); expect_eq("R10 flag survives warm reset", v, 32'h10);
        peek(4'd0, v); expect_eq("R10 counter cleared by warm reset", v, 32'd0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        peek(4'd4, v); expect_eq("R10 flag cleared by power-on reset", v, 32'd0);

        put(4'd0, 32'h5A5A_FFF0);
        wait_idle();
        put(4'd4, 32'hA5A5_A582);
        addr = 4'd0;
        repeat (32) @(posedge clk);
        #1 expect_eq("R7 divide by 16", rdata, 32'h0000_FFF2);

        wait_idle();
        put(4'd4, 32'hA5A5_A586);
        repeat (3000) @(posedge clk);
        wait_idle();
        put(4'd4, 32'hA5A5_A500);
        wait_idle();
        put(4'd0, 32'h5A5A_FFFF);
        wait_idle();
        put(4'd4, 32'hA5A5_A587);
        addr = 4'd0;
        repeat (4095) @(posedge clk);
        #1 expect_eq("R7 divide by 4096, no step yet", {rdata[31:1], rst_req}, 32'h0000_FFFE);
        @(posedge clk);
        #1 expect_eq("R7 R8 wrap after 4096 ticks", {rdata[31:1], rst_req}, 32'h0000_0001);
        repeat (20) @(posedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule